// File: doc/BRIEF.md
# Per-Channel Gain and Offset Trim

This block sits in front of a multichannel digital-to-analog converter and corrects every code before it reaches the converter. Each channel keeps three registers: a gain word, an offset word and a data word. A conversion scales the raw code by the channel's gain, adds the channel's offset relative to mid-scale, and clamps the result into the output code range. The final code leaves the block two clock cycles after it enters, together with its channel number.

A single write port programs the registers. It carries a channel number, a two-bit selector and a value. A write to the data word also starts a conversion of that value. A separate request port converts the stored data word of a channel again. This is useful after its gain or offset has changed. The resolution is set by a parameter, for example 16 or 14 bits, and all reset defaults and limits follow from it. A synchronous reset returns every channel to unity gain and a mid-scale offset.

Top module: `gain_offset_trim`

## Requirements
- R1: After reset every channel has gain word 2^N-1 (all ones) and offset word 2^(N-1), so any code X is returned unchanged, and the data word is 0. No output is valid while reset is held.
- R2: A conversion started at a clock edge gives outValid high at the second following edge, with outCh equal to its channel. One conversion can start on every cycle.
- R3: The corrected code is floor(X*(m+1)/2^N) + c - 2^(N-1), where X is the code, m the gain word and c the offset word. It is passed through unchanged when it lies inside 0 to 2^N-1.
- R4: A gain word of 2^(N-1)-1 halves the slope: the output is floor(X/2) at the default offset, and the size of one output step is unchanged.
- R5: One offset step equals one data step: data X+k with offset c-k gives the same output as data X with offset c.
- R6: When the offset takes away more than the scaled data, the output is 0 and does not wrap.
- R7: When gain and offset push the result above full scale, the output is 2^N-1 and does not wrap.
- R8: A gain or offset write affects conversions that start on a later cycle. A conversion that starts at the same edge as the write uses the old value.
- R9: A write to one channel's gain, offset or data leaves every other channel's conversion result unchanged.
- R10: Selector encoding: 2'b00 writes the gain word, 2'b01 the offset word, 2'b10 the data word and starts a conversion of it. 2'b11 has no effect: no output, and no register change.
- R11: reqValid starts a conversion of channel reqCh's stored data word. When a data write happens on the same cycle, the request is dropped and only the data write is converted.
- R12: Asserting the synchronous reset after registers were changed restores the R1 defaults on every channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select (R10 encoding) |
| wrCh | input | $clog2(NUM_CH) | Channel addressed by the write |
| wrData | input | DATA_W | Value written |
| reqValid | input | 1 | Request to convert a channel's stored data word |
| reqCh | input | $clog2(NUM_CH) | Channel of the request |
| outValid | output | 1 | Corrected code valid |
| outCh | output | $clog2(NUM_CH) | Channel of the corrected code |
| outCode | output | DATA_W | Corrected, clamped code |

## Verification
A wrong gain or offset word shows up as a wrong outCode at the second edge after the next conversion on that channel. A wrong data word shows up at the second edge after a request on that channel. A slip in the valid or channel pipeline shows up on the very next cycle as an extra, missing or mislabelled outValid, because the bench compares every cycle. Clamping faults only appear when a code crosses a range end, so the stimulus deliberately drives results below zero and above full scale, and places writes on the same edge as conversions.

// File: rtl/trim_pkg.sv
package trim_pkg;

  typedef enum logic [1:0] {
    SEL_GAIN   = 2'b00,
    SEL_OFFSET = 2'b01,
    SEL_DATA   = 2'b10,
    SEL_NONE   = 2'b11
  } wr_sel_e;

  typedef struct packed {
    logic gainWr;
    logic offsetWr;
    logic dataWr;
    logic launch;
    logic fromReg;
  } ctrl_strobe_t;

endpackage

// File: rtl/trim_ctrl.sv
module trim_ctrl
  import trim_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [CH_W-1:0]  wrCh,
  input  logic             reqValid,
  input  logic [CH_W-1:0]  reqCh,
  output ctrl_strobe_t     strobe,
  output logic [CH_W-1:0]  launchCh,
  output logic             s1Valid,
  output logic             outValid,
  output logic [CH_W-1:0]  outCh
);

  wr_sel_e sel;
  logic [CH_W-1:0] s1Ch;

  assign sel = wr_sel_e'(wrSel);

  // Decode the write into strobes; a data write claims the pipeline entry.
  always_comb begin
    strobe = '0;
    if (wrEn) begin
      case (sel)
        SEL_GAIN:   strobe.gainWr   = 1'b1;
        SEL_OFFSET: strobe.offsetWr = 1'b1;
        SEL_DATA:   strobe.dataWr   = 1'b1;
        default:    ;
      endcase
    end
    strobe.launch  = strobe.dataWr | reqValid;
    strobe.fromReg = ~strobe.dataWr;
  end

  assign launchCh = strobe.dataWr ? wrCh : reqCh;

  // Valid and channel travel alongside the two datapath stages.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1Valid  <= 1'b0;
      s1Ch     <= '0;
      outValid <= 1'b0;
      outCh    <= '0;
    end else begin
      s1Valid  <= strobe.launch;
      outValid <= s1Valid;
      if (strobe.launch) s1Ch  <= launchCh;
      if (s1Valid)       outCh <= s1Ch;
    end
  end

endmodule

// File: rtl/trim_regs.sv
module trim_regs #(
  parameter int DATA_W = 16,
  parameter int NUM_CH = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gainWr,
  input  logic              offsetWr,
  input  logic              dataWr,
  input  logic [CH_W-1:0]   wrCh,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CH_W-1:0]   rdCh,
  output logic [DATA_W-1:0] rdGain,
  output logic [DATA_W-1:0] rdOffset,
  output logic [DATA_W-1:0] rdData
);

  localparam logic [DATA_W-1:0] GAIN_RST = '1;
  localparam logic [DATA_W-1:0] OFFS_RST = {1'b1, {(DATA_W-1){1'b0}}};

  logic [NUM_CH-1:0][DATA_W-1:0] gainBus;
  logic [NUM_CH-1:0][DATA_W-1:0] offsetBus;
  logic [NUM_CH-1:0][DATA_W-1:0] dataBus;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic              hit;
    logic [DATA_W-1:0] gainQ;
    logic [DATA_W-1:0] offsetQ;
    logic [DATA_W-1:0] dataQ;

    assign hit = (wrCh == CH_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        gainQ   <= GAIN_RST;
        offsetQ <= OFFS_RST;
        dataQ   <= '0;
      end else if (hit) begin
        if (gainWr)   gainQ   <= wrData;
        if (offsetWr) offsetQ <= wrData;
        if (dataWr)   dataQ   <= wrData;
      end
    end

    assign gainBus[g]   = gainQ;
    assign offsetBus[g] = offsetQ;
    assign dataBus[g]   = dataQ;
  end

  assign rdGain   = gainBus[rdCh];
  assign rdOffset = offsetBus[rdCh];
  assign rdData   = dataBus[rdCh];

endmodule

// File: rtl/trim_math.sv
module trim_math #(
  parameter int DATA_W = 16,
  localparam int PROD_W = 2 * DATA_W + 1,
  localparam int SCL_W  = DATA_W + 1,
  localparam int SUM_W  = DATA_W + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    launch,
  input  logic                    fromReg,
  input  logic                    s1Valid,
  input  logic [DATA_W-1:0]       wrData,
  input  logic [DATA_W-1:0]       regData,
  input  logic [DATA_W-1:0]       gain,
  input  logic [DATA_W-1:0]       offset,
  output logic signed [SUM_W-1:0] rawSum,
  output logic [DATA_W-1:0]       outCode
);

  localparam logic [SUM_W-1:0]        MID_EXT = SUM_W'({1'b1, {(DATA_W-1){1'b0}}});
  localparam logic signed [SUM_W-1:0] TOP_EXT = SUM_W'({DATA_W{1'b1}});

  logic [DATA_W-1:0] code;
  logic [SCL_W-1:0]  gainP1;
  logic [PROD_W-1:0] fullProd;
  logic [SCL_W-1:0]  scaled;
  logic [SCL_W-1:0]  s1Scaled;
  logic [DATA_W-1:0] s1Offset;
  logic [DATA_W-1:0] satCode;

  // Stage 1: pick the code, scale by (gain + 1) / 2^N.
  assign code     = fromReg ? regData : wrData;
  assign gainP1   = {1'b0, gain} + SCL_W'(1);
  assign fullProd = PROD_W'(code) * PROD_W'(gainP1);
  assign scaled   = SCL_W'(fullProd >> DATA_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Scaled <= '0;
      s1Offset <= '0;
    end else if (launch) begin
      s1Scaled <= scaled;
      s1Offset <= offset;
    end
  end

  // Stage 2: add the offset about mid-scale and clamp to the code range.
  assign rawSum = SUM_W'({1'b0, s1Scaled}) + SUM_W'({2'b00, s1Offset}) - MID_EXT;

  always_comb begin
    if (rawSum[SUM_W-1])      satCode = '0;
    else if (rawSum > TOP_EXT) satCode = '1;
    else                       satCode = rawSum[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)          outCode <= '0;
    else if (s1Valid) outCode <= satCode;
  end

endmodule

// File: rtl/gain_offset_trim.sv
module gain_offset_trim
  import trim_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NUM_CH = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wrEn,
  input  logic [1:0]                 wrSel,
  input  logic [$clog2(NUM_CH)-1:0]  wrCh,
  input  logic [DATA_W-1:0]          wrData,
  input  logic                       reqValid,
  input  logic [$clog2(NUM_CH)-1:0]  reqCh,
  output logic                       outValid,
  output logic [$clog2(NUM_CH)-1:0]  outCh,
  output logic [DATA_W-1:0]          outCode
);

  localparam int CH_W  = $clog2(NUM_CH);
  localparam int SUM_W = DATA_W + 2;

  ctrl_strobe_t             strobe;
  logic [CH_W-1:0]          launchCh;
  logic                     s1Valid;
  logic [DATA_W-1:0]        rdGain;
  logic [DATA_W-1:0]        rdOffset;
  logic [DATA_W-1:0]        rdData;
  logic signed [SUM_W-1:0]  rawSum;

  trim_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .wrCh     (wrCh),
    .reqValid (reqValid),
    .reqCh    (reqCh),
    .strobe   (strobe),
    .launchCh (launchCh),
    .s1Valid  (s1Valid),
    .outValid (outValid),
    .outCh    (outCh)
  );

  trim_regs #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .gainWr   (strobe.gainWr),
    .offsetWr (strobe.offsetWr),
    .dataWr   (strobe.dataWr),
    .wrCh     (wrCh),
    .wrData   (wrData),
    .rdCh     (launchCh),
    .rdGain   (rdGain),
    .rdOffset (rdOffset),
    .rdData   (rdData)
  );

  trim_math #(.DATA_W(DATA_W)) u_math (
    .clk     (clk),
    .rst     (rst),
    .launch  (strobe.launch),
    .fromReg (strobe.fromReg),
    .s1Valid (s1Valid),
    .wrData  (wrData),
    .regData (rdData),
    .gain    (rdGain),
    .offset  (rdOffset),
    .rawSum  (rawSum),
    .outCode (outCode)
  );

endmodule

// File: rtl/gain_offset_trim_chk.sv
module gain_offset_trim_chk #(
  parameter int DATA_W = 16,
  parameter int NUM_CH = 8,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int SUM_W = DATA_W + 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      wrEn,
  input logic [1:0]                wrSel,
  input logic [CH_W-1:0]           wrCh,
  input logic                      reqValid,
  input logic [CH_W-1:0]           reqCh,
  input logic                      outValid,
  input logic [CH_W-1:0]           outCh,
  input logic [DATA_W-1:0]         outCode,
  input logic                      s1Valid,
  input logic signed [SUM_W-1:0]   rawSum
);

  localparam logic signed [SUM_W-1:0] TOP_EXT = SUM_W'({DATA_W{1'b1}});

  logic [1:0]      sinceRst;
  logic            dataLaunch;
  logic            launch;
  logic [CH_W-1:0] launchCh;
  logic            idleSel;
  logic            sumNeg;
  logic            sumHigh;

  always_ff @(posedge clk) begin
    if (rst)                sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  assign dataLaunch = wrEn && (wrSel == 2'b10);
  assign launch     = dataLaunch || reqValid;
  assign launchCh   = dataLaunch ? wrCh : reqCh;
  assign idleSel    = wrEn && (wrSel == 2'b11) && !reqValid;
  assign sumNeg     = rawSum[SUM_W-1];
  assign sumHigh    = !sumNeg && (rawSum > TOP_EXT);

  // R2: outValid follows a launch by exactly two edges
  p_two_cycle_r2: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 2'd2) |-> (outValid == $past(launch, 2)));

  // R2: channel tag travels with the code
  p_chan_tag_r2: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 2'd2 && outValid) |-> (outCh == $past(launchCh, 2)));

  // R6: negative sums clamp to zero
  p_floor_clamp_r6: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 2'd1 && $past(s1Valid) && $past(sumNeg)) |-> (outValid && outCode == '0));

  // R7: sums above full scale clamp to the top code
  p_ceiling_clamp_r7: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 2'd1 && $past(s1Valid) && $past(sumHigh)) |-> (outValid && outCode == '1));

  // R3: in-range sums pass through unchanged
  p_in_range_r3: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 2'd1 && $past(s1Valid) && !$past(sumNeg) && !$past(sumHigh))
      |-> (outCode == $past(rawSum[DATA_W-1:0])));

  // R10: selector 2'b11 with no request produces no output
  p_unused_sel_r10: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 2'd2 && $past(idleSel, 2)) |-> !outValid);

endmodule

bind gain_offset_trim gain_offset_trim_chk #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wrEn     (wrEn),
  .wrSel    (wrSel),
  .wrCh     (wrCh),
  .reqValid (reqValid),
  .reqCh    (reqCh),
  .outValid (outValid),
  .outCh    (outCh),
  .outCode  (outCode),
  .s1Valid  (s1Valid),
  .rawSum   (rawSum)
);

// File: tb/tb_gain_offset_trim.sv
`timescale 1ns/1ps
module tb_gain_offset_trim;

  localparam int DW   = 16;
  localparam int NCH  = 8;
  localparam int CW   = $clog2(NCH);
  localparam int FULL = (1 << DW) - 1;
  localparam int MID  = 1 << (DW - 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wrEn = 1'b0;
  logic [1:0]    wrSel = '0;
  logic [CW-1:0] wrCh = '0;
  logic [DW-1:0] wrData = '0;
  logic          reqValid = 1'b0;
  logic [CW-1:0] reqCh = '0;
  logic          outValid;
  logic [CW-1:0] outCh;
  logic [DW-1:0] outCode;

  gain_offset_trim #(.DATA_W(DW), .NUM_CH(NCH)) dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrSel(wrSel), .wrCh(wrCh), .wrData(wrData),
    .reqValid(reqValid), .reqCh(reqCh), .outValid(outValid), .outCh(outCh), .outCode(outCode)
  );

  always #2 clk = ~clk;

  typedef struct {
    int    due;
    int    ch;
    int    code;
    string tag;
  } exp_t;

  exp_t  expQ[$];
  int    mModel[NCH];
  int    cModel[NCH];
  int    dModel[NCH];
  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    checking = 1'b0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int refCode(int x, int m, int c);
    longint p;
    longint s;
    p = (longint'(x) * longint'(m + 1)) >>> DW;
    s = p + longint'(c) - longint'(MID);
    if (s < 0) return 0;
    if (s > FULL) return FULL;
    return int'(s);
  endfunction

  task automatic modelReset();
    for (int i = 0; i < NCH; i++) begin
      mModel[i] = FULL;
      cModel[i] = MID;
      dModel[i] = 0;
    end
    expQ.delete();
  endtask

  task automatic check(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // Compare the ports with the model on every clock, away from the edge.
  always @(negedge clk) begin
    exp_t e;
    if (checking && !rst) begin
      if (expQ.size() > 0 && expQ[0].due == cyc) begin
        e = expQ.pop_front();
        check(outValid == 1'b1, e.tag, "outValid", int'(outValid), 1);
        check(int'(outCh) == e.ch, e.tag, "outCh", int'(outCh), e.ch);
        check(int'(outCode) == e.code, e.tag, "outCode", int'(outCode), e.code);
      end else begin
        check(outValid == 1'b0, "R2", "spurious outValid", int'(outValid), 0);
      end
    end
  end

  task automatic drive(bit we, bit [1:0] sel, int ch, int dat, bit rq, int rch, string tag);
    @(posedge clk);
    #1;
    wrEn     = we;
    wrSel    = sel;
    wrCh     = CW'(ch);
    wrData   = DW'(dat);
    reqValid = rq;
    reqCh    = CW'(rch);
    if (we && sel == 2'b10)
      expQ.push_back('{cyc + 2, ch, refCode(dat & FULL, mModel[ch], cModel[ch]), tag});
    else if (rq)
      expQ.push_back('{cyc + 2, rch, refCode(dModel[rch], mModel[rch], cModel[rch]), tag});
    if (we) begin
      case (sel)
        2'b00: mModel[ch] = dat & FULL;
        2'b01: cModel[ch] = dat & FULL;
        2'b10: dModel[ch] = dat & FULL;
        default: ;
      endcase
    end
  endtask

  task automatic idle(int n);
    repeat (n) drive(1'b0, 2'b00, 0, 0, 1'b0, 0, "R2");
  endtask

  task automatic conv(int ch, int dat, string tag);
    drive(1'b1, 2'b10, ch, dat, 1'b0, 0, tag);
  endtask

  task automatic setReg(bit [1:0] sel, int ch, int val, string tag);
    drive(1'b1, sel, ch, val, 1'b0, 0, tag);
  endtask

  task automatic pulseReset(string tag);
    @(posedge clk);
    #1;
    rst = 1'b1;
    wrEn = 1'b0;
    reqValid = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check(outValid == 1'b0, tag, "outValid in reset", int'(outValid), 0);
    modelReset();
    rst = 1'b0;
  endtask

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    #1;
    check(outValid == 1'b0, "R1", "outValid in reset", int'(outValid), 0);
    rst = 1'b0;
    checking = 1'b1;

    // R1: defaults give identity on every channel; R3 mid-range pass
    for (int i = 0; i < NCH; i++) conv(i, (i * 9001 + 77) & FULL, "R1");
    conv(0, 0, "R1");
    conv(7, FULL, "R1");
    drive(1'b0, 2'b00, 0, 0, 1'b1, 3, "R1");
    idle(3);

    // R3: general transfer with odd gain and offset
    setReg(2'b00, 2, 40000, "R3");
    setReg(2'b01, 2, MID + 1234, "R3");
    conv(2, 50000, "R3");
    conv(2, 12345, "R3");
    idle(3);

    // R4: half gain halves the span, step size unchanged
    setReg(2'b00, 1, MID - 1, "R4");
    conv(1, FULL, "R4");
    conv(1, 1000, "R4");
    conv(1, 1001, "R4");
    idle(3);

    // R5: data+k with offset-k equals data with default offset
    setReg(2'b01, 3, MID - 10, "R5");
    conv(3, 200, "R5");
    conv(4, 190, "R5");
    idle(3);

    // R6: offset removal beyond data clamps at zero
    setReg(2'b01, 3, MID - 50, "R6");
    conv(3, 20, "R6");
    conv(3, 50, "R6");
    idle(3);

    // R7: high clamp
    setReg(2'b01, 4, MID + 100, "R7");
    conv(4, 16'hFFF0, "R7");
    conv(4, FULL - 100, "R7");
    idle(3);

    // R8: gain write on same edge as a request uses old gain, next cycle new
    conv(5, 30000, "R8");
    drive(1'b1, 2'b00, 5, 0, 1'b1, 5, "R8");
    drive(1'b0, 2'b00, 0, 0, 1'b1, 5, "R8");
    drive(1'b1, 2'b01, 5, MID + 7, 1'b1, 5, "R8");
    drive(1'b0, 2'b00, 0, 0, 1'b1, 5, "R8");
    idle(3);

    // R9: other channels untouched by channel 5 changes
    conv(6, 30000, "R9");
    drive(1'b0, 2'b00, 0, 0, 1'b1, 0, "R9");
    idle(3);

    // R10: selector 2'b11 writes nothing and launches nothing
    conv(0, 4321, "R10");
    idle(2);
    setReg(2'b11, 0, 5, "R10");
    idle(3);
    drive(1'b0, 2'b00, 0, 0, 1'b1, 0, "R10");
    setReg(2'b11, 1, 0, "R10");
    conv(1, 1000, "R10");
    idle(3);

    // R11: request converts stored data; dropped when a data write coincides
    conv(2, 777, "R11");
    drive(1'b0, 2'b00, 0, 0, 1'b1, 2, "R11");
    drive(1'b1, 2'b10, 6, 999, 1'b1, 2, "R11");
    idle(3);

    // R2: back-to-back stream with mixed channels and sources
    for (int i = 0; i < NCH; i++) setReg(2'b00, i, (i * 7333 + 20000) & FULL, "R2");
    for (int i = 0; i < 48; i++) begin
      if (i % 3 == 2) drive(1'b0, 2'b00, 0, 0, 1'b1, (i * 5) % NCH, "R2");
      else conv(i % NCH, (i * 7919 + 13) & FULL, "R2");
    end
    idle(3);

    // R12: reset restores defaults after changes
    pulseReset("R12");
    for (int i = 0; i < NCH; i++) conv(i, (i * 3001 + 5) & FULL, "R12");
    drive(1'b0, 2'b00, 0, 0, 1'b1, 3, "R12");
    idle(4);

    check(expQ.size() == 0, "R2", "outstanding results", expQ.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule